// File: doc/BRIEF.md
# Dual-Section Decade Counter

A four-bit counter made of two sections that can work alone or be chained. Bit 0 is a divide-by-two toggle stage. Bits 3..1 form a divide-by-five stage that counts in binary from 0 to 4 and then wraps. Each section has its own count input. A section advances one clock after the system clock sees a falling edge on its count source. A two-bit link selector sets how the sections are joined. In split mode they are not joined. In decimal mode the toggle stage drives the five stage, so the output counts 0 to 9 in natural binary. In bi-quinary mode the five stage drives the toggle stage, so bit 0 becomes a square wave at one tenth of the input rate.

Links between the sections are detected synchronously. When a driving stage steps from its top value back to its low value, a one-cycle pulse is registered, and the driven stage advances on the next clock. This gives the same behaviour as a ripple chain while every flop stays on one clock. A clear pair and a preset pair control the counter directly. When both clear inputs are high, the count is forced to zero. When both preset inputs are high, the count is forced to nine, and preset wins over clear. In decimal mode a one-cycle carry flags each wrap from nine to zero. Wiring bit 3 of one instance to the first count input of a second instance gives a counter from 0 to 99.

Top module: `dual_decade_counter`

## Requirements
- R1: While rst_n is low and right after it is released, q is 0000 and carry is 0.
- R2: The toggle stage (q[0]) inverts one clock after each falling edge of its count source. It does not change at any other time, except when clear or preset is active.
- R3: The five stage (q[3:1], read as an unsigned number) steps 0,1,2,3,4,0 on each falling edge of its count source. It never holds a value above 4.
- R4: With link_mode 00 or 11, a falling edge on cnt_a moves only q[0], and a falling edge on cnt_b moves only q[3:1].
- R5: With link_mode 01, after n falling edges on cnt_a, q settles to n mod 10 within three clocks of the last edge.
- R6: With link_mode 10, after n falling edges on cnt_b, q[3:1] settles to n mod 5 and q[0] to (n/5) mod 2. Bit 0 is therefore high for five input counts and low for five.
- R7: With clr == 2'b11 and pre not 2'b11, q is 0000 one clock later. A clear pair that is not fully high has no effect.
- R8: With pre == 2'b11, q is 1001 one clock later, whatever clr is. A preset pair that is not fully high has no effect.
- R9: carry is high for exactly one clock, and only in link_mode 01, each time the count wraps from 9 to 0. During that clock q reads 0000.
- R10: When q[3] of a low instance drives cnt_a of a high instance, and both use link_mode 01, the pair reads (n mod 10, (n/10) mod 10) after n input edges and returns to 00 on the hundredth.
- R11: Count edges that arrive while clear or preset is active are dropped. The count does not move once the controls are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_a | input | 1 | Count input of the toggle stage (falling edge counts) |
| cnt_b | input | 1 | Count input of the five stage (falling edge counts) |
| link_mode | input | 2 | 00/11 split, 01 decimal, 10 bi-quinary |
| clr | input | 2 | Clear pair; both high forces 0000 |
| pre | input | 2 | Preset pair; both high forces 1001, over clear |
| q | output | 4 | Count; q[0] toggle stage, q[3:1] five stage |
| carry | output | 1 | One-clock pulse on a decimal wrap from 9 to 0 |

## Verification
On every cycle the assertions check the following: the five stage stays within 0..4, and each section moves only after its own step pulse. Clear and preset take effect one cycle after they are applied. Carry lasts a single cycle, falls on a zero count and appears only in decimal mode. In split mode the five stage is stepped only by its own input edge. The bench scenarios show the whole-sequence results that no single-cycle property can express: the decimal and bi-quinary orders over many input edges, the ten-count square wave on bit 0, the number of carries, the dropping of edges during clear or preset, and the cascaded sweep from 0 to 99 and back.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  typedef enum logic [1:0] {
    LINK_SPLIT     = 2'b00,
    LINK_DECIMAL   = 2'b01,
    LINK_BIQUINARY = 2'b10,
    LINK_SPLIT_ALT = 2'b11
  } link_mode_e;

  localparam int          QUIN_W    = 3;
  localparam int          COUNT_W   = QUIN_W + 1;
  localparam logic [QUIN_W-1:0] QUIN_TOP  = 3'd4;
  localparam logic [QUIN_W-1:0] QUIN_NINE = 3'd4;   // five-stage part of nine
  localparam logic              TOG_NINE  = 1'b1;   // toggle part of nine

  // next value of the five stage: binary 0..QUIN_TOP, then back to zero
  function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] v);
    if (v >= QUIN_TOP) return '0;
    return v + 1'b1;
  endfunction

  // the five stage leaves its top value on this step
  function automatic logic quin_at_top(input logic [QUIN_W-1:0] v);
    return v >= QUIN_TOP;
  endfunction

  function automatic logic is_split(input link_mode_e m);
    return (m == LINK_SPLIT) || (m == LINK_SPLIT_ALT);
  endfunction

endpackage

// File: rtl/ddc_fall_detect.sv
module ddc_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign fall = prev_q & ~level;
endmodule

// File: rtl/ddc_toggle_stage.sv
module ddc_toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic force_set,
  input  logic force_clr,
  input  logic step,
  output logic bit_q,
  output logic wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)         bit_q <= 1'b0;
    else if (force_set) bit_q <= ddc_pkg::TOG_NINE;
    else if (force_clr) bit_q <= 1'b0;
    else if (step)      bit_q <= ~bit_q;
  end

  // a counted 1 -> 0 transition on this stage
  assign wrap = step & bit_q & ~force_set & ~force_clr;
endmodule

// File: rtl/ddc_quinary_stage.sv
module ddc_quinary_stage
  import ddc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_set,
  input  logic              force_clr,
  input  logic              step,
  output logic [QUIN_W-1:0] val_q,
  output logic              wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)         val_q <= '0;
    else if (force_set) val_q <= QUIN_NINE;
    else if (force_clr) val_q <= '0;
    else if (step)      val_q <= quin_next(val_q);
  end

  assign wrap = step & quin_at_top(val_q) & ~force_set & ~force_clr;
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import ddc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_a,
  input  logic         cnt_b,
  input  logic [1:0]   link_mode,
  input  logic [1:0]   clr,
  input  logic [1:0]   pre,
  output logic [3:0]   q,
  output logic         carry
);
  localparam int NUM_EXT = 2;

  link_mode_e mode_e;
  assign mode_e = link_mode_e'(link_mode);

  // named internal events, also observed by the checker
  logic preset_act, clear_act;
  logic fall_a, fall_b;
  logic step_a, step_b;
  logic wrap_a, wrap_b;
  logic link_to_b_q, link_to_a_q;
  logic carry_q;

  assign preset_act = &pre;
  assign clear_act  = &clr;

  logic [NUM_EXT-1:0] ext_level, ext_fall;
  assign ext_level = {cnt_b, cnt_a};

  for (genvar gi = 0; gi < NUM_EXT; gi++) begin : g_edge
    ddc_fall_detect u_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .level (ext_level[gi]),
      .fall  (ext_fall[gi])
    );
  end

  assign fall_a = ext_fall[0];
  assign fall_b = ext_fall[1];

  // source selection for each section
  assign step_a = (mode_e == LINK_BIQUINARY) ? link_to_a_q : fall_a;
  assign step_b = (mode_e == LINK_DECIMAL)   ? link_to_b_q : fall_b;

  logic              tog_q;
  logic [QUIN_W-1:0] quin_q;

  ddc_toggle_stage u_tog (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_set (preset_act),
    .force_clr (clear_act),
    .step      (step_a),
    .bit_q     (tog_q),
    .wrap      (wrap_a)
  );

  ddc_quinary_stage u_quin (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_set (preset_act),
    .force_clr (clear_act),
    .step      (step_b),
    .val_q     (quin_q),
    .wrap      (wrap_b)
  );

  // inter-section links and carry, one register stage each
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_to_b_q <= 1'b0;
      link_to_a_q <= 1'b0;
      carry_q     <= 1'b0;
    end else begin
      link_to_b_q <= (mode_e == LINK_DECIMAL)   & wrap_a;
      link_to_a_q <= (mode_e == LINK_BIQUINARY) & wrap_b;
      carry_q     <= (mode_e == LINK_DECIMAL)   & wrap_b;
    end
  end

  assign q     = {quin_q, tog_q};
  assign carry = carry_q;
endmodule

// File: rtl/ddc_checker.sv
module ddc_checker
  import ddc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] link_mode,
  input logic [3:0] q,
  input logic       carry,
  input logic       preset_act,
  input logic       clear_act,
  input logic       step_a,
  input logic       step_b,
  input logic       fall_b
);
  a_r3_five_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    q[3:1] <= QUIN_TOP);

  a_r2_toggle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_a && !preset_act && !clear_act) |=> $stable(q[0]));

  a_r3_five_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_b && !preset_act && !clear_act) |=> $stable(q[3:1]));

  a_r4_split_source: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == 2'b00 || link_mode == 2'b11) |-> (step_b == fall_b));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_act && !preset_act) |=> (q == 4'd0));

  a_r8_preset: assert property (@(posedge clk) disable iff (!rst_n)
    preset_act |=> (q == 4'd9));

  a_r9_carry_single: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> !carry);

  a_r9_carry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (q == 4'd0));

  a_r9_carry_decimal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carry) |-> ($past(link_mode) == 2'b01));
endmodule

bind dual_decade_counter ddc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .link_mode  (link_mode),
  .q          (q),
  .carry      (carry),
  .preset_act (preset_act),
  .clear_act  (clear_act),
  .step_a     (step_a),
  .step_b     (step_b),
  .fall_b     (fall_b)
);

// File: tb/dual_decade_counter_test.sv
module dual_decade_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ca = 1'b0, cb = 1'b0;
  logic [1:0] mode = 2'b01, clr = 2'b00, pre = 2'b00;
  logic [3:0] q;
  logic carry;

  logic c_in = 1'b0;
  logic [3:0] q_lo, q_hi;
  logic carry_lo, carry_hi;

  int total = 0, bad = 0, carry_cycles = 0;

  always #10 clk = ~clk;

  dual_decade_counter uut (
    .clk(clk), .rst_n(rst_n), .cnt_a(ca), .cnt_b(cb), .link_mode(mode),
    .clr(clr), .pre(pre), .q(q), .carry(carry));

  dual_decade_counter uut_lo (
    .clk(clk), .rst_n(rst_n), .cnt_a(c_in), .cnt_b(1'b0), .link_mode(2'b01),
    .clr(2'b00), .pre(2'b00), .q(q_lo), .carry(carry_lo));

  dual_decade_counter uut_hi (
    .clk(clk), .rst_n(rst_n), .cnt_a(q_lo[3]), .cnt_b(1'b0), .link_mode(2'b01),
    .clr(2'b00), .pre(2'b00), .q(q_hi), .carry(carry_hi));

  always @(negedge clk) if (rst_n && carry) carry_cycles++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    ca = 1'b1; tick(2); ca = 1'b0; tick(4);
  endtask

  task automatic pulse_b();
    cb = 1'b1; tick(2); cb = 1'b0; tick(4);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int exp_carry;
    int na, nb;
    tick(3);
    chk(q == 4'd0 && carry == 1'b0, "R1", q, 0);
    rst_n = 1'b1;
    tick(1);
    chk(q == 4'd0 && carry == 1'b0, "R1", q, 0);

    // R5 decimal sweep, R9 carry count
    mode = 2'b01;
    for (int n = 1; n <= 25; n++) begin
      pulse_a();
      chk(q == 4'(n % 10), "R5", q, n % 10);
    end
    chk(carry_cycles == 2, "R9", carry_cycles, 2);

    // R7 clear, then partial clear ignored
    clr = 2'b11; tick(2); clr = 2'b00;
    chk(q == 4'd0, "R7", q, 0);
    for (int n = 0; n < 3; n++) pulse_a();
    clr = 2'b01; tick(3);
    chk(q == 4'd3, "R7", q, 3);
    clr = 2'b00;
    pre = 2'b10; tick(3);
    chk(q == 4'd3, "R8", q, 3);
    pre = 2'b00;

    // R6 bi-quinary sweep; no carry outside decimal mode (R9)
    clr = 2'b11; tick(2); clr = 2'b00;
    mode = 2'b10;
    exp_carry = carry_cycles;
    for (int n = 1; n <= 20; n++) begin
      pulse_b();
      chk(q == {3'(n % 5), 1'((n / 5) % 2)}, "R6", q, ((n % 5) << 1) | ((n / 5) % 2));
    end
    chk(carry_cycles == exp_carry, "R9", carry_cycles, exp_carry);

    // R4 split modes, both encodings
    for (int m = 0; m < 2; m++) begin
      clr = 2'b11; tick(2); clr = 2'b00;
      mode = (m == 0) ? 2'b00 : 2'b11;
      na = 0; nb = 0;
      for (int i = 0; i < 12; i++) begin
        if (i % 3 == 0) begin pulse_a(); na++; end
        else begin pulse_b(); nb++; end
        chk(q == {3'(nb % 5), 1'(na % 2)}, "R4", q, ((nb % 5) << 1) | (na % 2));
      end
    end

    // R8 preset over clear, R11 edges dropped while held
    mode = 2'b01;
    pre = 2'b11; clr = 2'b11; tick(2);
    chk(q == 4'd9, "R8", q, 9);
    pulse_a(); pulse_a();
    clr = 2'b00; pulse_b();
    pre = 2'b00; tick(3);
    chk(q == 4'd9, "R11", q, 9);
    exp_carry = carry_cycles + 1;
    pulse_a();
    chk(q == 4'd0, "R5", q, 0);
    chk(carry_cycles == exp_carry, "R9", carry_cycles, exp_carry);
    pulse_a(); pulse_a();
    clr = 2'b11; pulse_a(); clr = 2'b00; tick(2);
    chk(q == 4'd0, "R11", q, 0);

    // R10 cascade sweep through 0..99 and back to 00
    for (int n = 1; n <= 105; n++) begin
      c_in = 1'b1; tick(2); c_in = 1'b0; tick(8);
      chk(q_lo == 4'(n % 10) && q_hi == 4'((n / 10) % 10), "R10",
          q_hi * 10 + q_lo, n % 100);
    end
    finish_run();
  end
endmodule